// File: doc/BRIEF.md
# Capture and Match Timer

This block is a general-purpose timer for a peripheral subsystem. A free-running counter advances once for every full cycle of a programmable prescaler. The prescaler counts either peripheral-clock cycles or rising edges on one capture pin that has been chosen as an external count clock. Four compare registers watch the counter. On a hit, each one can flag an interrupt, wrap the counter, halt it, and set, clear or toggle its own output pin.

Capture pins pass through a two-flop synchroniser and an edge detector. On the edge polarity chosen for a channel, that channel latches the current count into its own register. One capture pin can serve as the external clock while the other pins still capture. Software programs the block through a simple write port. Interrupt flags stay set until software clears them by writing 1 to the flag's bit. The interrupt request is the OR of all flags.

Top module: `capture_match_timer`

## Requirements
- R1: After reset the count, every capture register, every match pin, every interrupt flag, the interrupt request and the counting status are all 0.
- R2: With counting enabled and the internal clock selected (control word 0x1), the count rises by one for every PRESC+1 clock cycles, where PRESC is the value at address 1.
- R3: While control bit 1 (soft clear) is set, the count and the prescaler stay at 0 even when bit 0 (run) is also set.
- R4: A match event occurs on the count tick that loads the counter with a value equal to that match's compare register (addresses 8 to 11). If bit 5i+0 of the match configuration word (address 2) is set, the event sets interrupt flag i, and irq_o is high whenever any flag is set.
- R5: If bit 5i+1 (wrap) is set, the counter holds the compare value for one tick period and then loads 0 instead of compare+1.
- R6: If bit 5i+2 (halt) is set, a match event clears the run bit, so counting_o falls and the count holds the compare value.
- R7: Bits 5i+4:5i+3 select the action of match pin i on its event: 00 keep, 01 drive low, 10 drive high, 11 toggle.
- R8: Capture channel c latches the count on a synchronised rising edge if bit 3c+0 of the capture configuration word (address 3) is set, and on a falling edge if bit 3c+1 is set. Both bits set gives both edges. An edge that is not enabled leaves the register unchanged.
- R9: If bit 3c+2 is set, a capture event on channel c sets interrupt flag 4+c.
- R10: Writing to address 4 clears exactly the flags whose bits are 1 in the data. Flags whose bits are 0 stay set.
- R11: With control bit 2 set, the prescaler counts rising edges of the capture pin selected by control bits 4:3 instead of clock cycles. No counting happens without such edges, and the other channels keep capturing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| cap_in | input | N_CAP | Asynchronous capture / count pins |
| count_o | output | CNT_W | Current counter value |
| counting_o | output | 1 | Run bit |
| cap_val_o | output | N_CAP*CNT_W | Capture registers, channel c at bits c*CNT_W upward |
| match_pin_o | output | N_MATCH | Match output pins |
| irq_flag_o | output | N_MATCH+N_CAP | Sticky flags: match flags low, capture flags above |
| irq_o | output | 1 | OR of all flags |

## Verification
A register write takes effect at the clock edge that samples it. A tick then follows on each later edge at which the prescaler reaches its limit, so with k edges after the run bit sets, the count equals k/(PRESC+1) modulo the wrap period. Match flags, pins and the halt change on the same edge as the tick that loads the compare value. A pin change lands on the third clock edge after it is sampled: two synchroniser stages, then the latch or count. The bench therefore waits at least five cycles after a pin change, or a fixed k cycles after a start, and samples on the falling edge.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_FLIP = 2'b11
  } pin_act_e;

  localparam int MCFG_W  = 5;  // irq, wrap, halt, action[1:0]
  localparam int CCFG_W  = 3;  // rise, fall, irq
  localparam int A_CTRL  = 0;
  localparam int A_PRESC = 1;
  localparam int A_MCFG  = 2;
  localparam int A_CCFG  = 3;
  localparam int A_CLR   = 4;
  localparam int A_MVAL0 = 8;

  function automatic logic pin_next(logic [1:0] act, logic cur);
    case (pin_act_e'(act))
      PIN_LOW:  return 1'b0;
      PIN_HIGH: return 1'b1;
      PIN_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction

  function automatic logic edge_hit(logic rise, logic fall, logic en_r, logic en_f);
    return (rise & en_r) | (fall & en_f);
  endfunction
endpackage

// File: rtl/cmt_sync_edge.sv
`timescale 1ns/1ps
module cmt_sync_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/cmt_prescale_count.sv
`timescale 1ns/1ps
module cmt_prescale_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         srst,
  input  logic         evt,
  input  logic [W-1:0] presc,
  input  logic         wrap_req,
  output logic [W-1:0] count,
  output logic [W-1:0] next_count,
  output logic         tick
);
  logic [W-1:0] pc_q, cnt_q;

  function automatic logic [W-1:0] pre_step(logic [W-1:0] pc, logic [W-1:0] lim);
    return (pc == lim) ? '0 : pc + 1'b1;
  endfunction

  function automatic logic [W-1:0] cnt_step(logic [W-1:0] c, logic wrap);
    return wrap ? '0 : c + 1'b1;
  endfunction

  assign tick       = run && !srst && evt && (pc_q == presc);
  assign next_count = cnt_step(cnt_q, wrap_req);
  assign count      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else if (srst) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (run && evt) pc_q <= pre_step(pc_q, presc);
      if (tick)       cnt_q <= next_count;
    end
  end
endmodule

// File: rtl/cmt_match_unit.sv
`timescale 1ns/1ps
module cmt_match_unit
  import cmt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] next_count,
  input  logic [W-1:0] mval,
  input  logic [1:0]   act,
  input  logic         rst_en,
  output logic         evt,
  output logic         rst_req,
  output logic         pin
);
  assign rst_req = rst_en && (count == mval);
  assign evt     = tick && (next_count == mval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pin <= 1'b0;
    else if (evt) pin <= pin_next(act, pin);
  end
endmodule

// File: rtl/capture_match_timer.sv
`timescale 1ns/1ps
module capture_match_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CNT_W-1:0]         wr_data,
  input  logic [N_CAP-1:0]         cap_in,
  output logic [CNT_W-1:0]         count_o,
  output logic                     counting_o,
  output logic [N_CAP*CNT_W-1:0]   cap_val_o,
  output logic [N_MATCH-1:0]       match_pin_o,
  output logic [N_MATCH+N_CAP-1:0] irq_flag_o,
  output logic                     irq_o
);
  localparam int SEL_W  = (N_CAP > 1) ? $clog2(N_CAP) : 1;
  localparam int FLAG_W = N_MATCH + N_CAP;
  localparam int MCFG_T = N_MATCH * MCFG_W;
  localparam int CCFG_T = N_CAP * CCFG_W;

  logic              run_q, srst_q, ext_q;
  logic [SEL_W-1:0]  sel_q;
  logic [CNT_W-1:0]  presc_q;
  logic [MCFG_T-1:0] mcfg_q;
  logic [CCFG_T-1:0] ccfg_q;
  logic [CNT_W-1:0]  mval_q [N_MATCH];
  logic [FLAG_W-1:0] flag_q;

  logic wr_ctrl, wr_presc, wr_mcfg, wr_ccfg, wr_clr;
  assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_presc = wr_en && (wr_addr == ADDR_W'(A_PRESC));
  assign wr_mcfg  = wr_en && (wr_addr == ADDR_W'(A_MCFG));
  assign wr_ccfg  = wr_en && (wr_addr == ADDR_W'(A_CCFG));
  assign wr_clr   = wr_en && (wr_addr == ADDR_W'(A_CLR));

  // internal events, brought out for the checker
  logic [N_CAP-1:0]   cap_rise, cap_fall, cap_evt, cap_irq_en;
  logic [N_MATCH-1:0] match_evt, rst_req, stop_vec, flip_vec, match_irq_en;
  logic               rst_req_any, tick, count_evt;
  logic [CNT_W-1:0]   count_q, next_cnt;
  logic [FLAG_W-1:0]  clr_mask, set_mask;

  assign rst_req_any = |rst_req;
  assign count_evt   = ext_q ? cap_rise[sel_q] : 1'b1;
  assign clr_mask    = wr_clr ? wr_data[FLAG_W-1:0] : '0;
  assign set_mask    = {cap_evt & cap_irq_en, match_evt & match_irq_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      srst_q  <= 1'b0;
      ext_q   <= 1'b0;
      sel_q   <= '0;
      presc_q <= '0;
      mcfg_q  <= '0;
      ccfg_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wr_data[0];
        srst_q <= wr_data[1];
        ext_q  <= wr_data[2];
        sel_q  <= wr_data[3 +: SEL_W];
      end
      if (|(match_evt & stop_vec)) run_q <= 1'b0;
      if (wr_presc) presc_q <= wr_data;
      if (wr_mcfg)  mcfg_q  <= wr_data[MCFG_T-1:0];
      if (wr_ccfg)  ccfg_q  <= wr_data[CCFG_T-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_mask) | set_mask;
  end

  cmt_sync_edge #(.N(N_CAP)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_in),
    .rise (cap_rise),
    .fall (cap_fall)
  );

  cmt_prescale_count #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .srst      (srst_q),
    .evt       (count_evt),
    .presc     (presc_q),
    .wrap_req  (rst_req_any),
    .count     (count_q),
    .next_count(next_cnt),
    .tick      (tick)
  );

  for (genvar i = 0; i < N_MATCH; i++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mval_q[i] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(A_MVAL0 + i))) mval_q[i] <= wr_data;
    end

    assign match_irq_en[i] = mcfg_q[i*MCFG_W + 0];
    assign stop_vec[i]     = mcfg_q[i*MCFG_W + 2];
    assign flip_vec[i]     = (mcfg_q[i*MCFG_W + 3 +: 2] == 2'b11);

    cmt_match_unit #(.W(CNT_W)) u_m (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .count     (count_q),
      .next_count(next_cnt),
      .mval      (mval_q[i]),
      .act       (mcfg_q[i*MCFG_W + 3 +: 2]),
      .rst_en    (mcfg_q[i*MCFG_W + 1]),
      .evt       (match_evt[i]),
      .rst_req   (rst_req[i]),
      .pin       (match_pin_o[i])
    );
  end

  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    logic [CNT_W-1:0] cap_q;
    assign cap_irq_en[c] = ccfg_q[c*CCFG_W + 2];
    assign cap_evt[c]    = edge_hit(cap_rise[c], cap_fall[c],
                                    ccfg_q[c*CCFG_W + 0], ccfg_q[c*CCFG_W + 1]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_q <= '0;
      else if (cap_evt[c]) cap_q <= count_q;
    end
    assign cap_val_o[c*CNT_W +: CNT_W] = cap_q;
  end

  assign count_o    = count_q;
  assign counting_o = run_q;
  assign irq_flag_o = flag_q;
  assign irq_o      = |flag_q;
endmodule

// File: rtl/cmt_checker.sv
`timescale 1ns/1ps
module cmt_checker #(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_FLAG  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srst,
  input logic               tick,
  input logic               wrap_req,
  input logic               counting,
  input logic [CNT_W-1:0]   count,
  input logic [N_MATCH-1:0] match_evt,
  input logic [N_MATCH-1:0] stop_vec,
  input logic [N_MATCH-1:0] flip_vec,
  input logic [N_MATCH-1:0] pins,
  input logic [N_FLAG-1:0]  flags,
  input logic [N_FLAG-1:0]  clr_mask
);
  p_srst_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (count == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && tick && !wrap_req) |=> (count == CNT_W'($past(count) + 1'b1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && !tick) |=> $stable(count));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && tick && wrap_req) |=> (count == '0));

  for (genvar i = 0; i < N_MATCH; i++) begin : g_m
    p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt[i] && stop_vec[i]) |=> !counting);
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt[i] && flip_vec[i]) |=> (pins[i] != $past(pins[i])));
  end

  for (genvar j = 0; j < N_FLAG; j++) begin : g_f
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[j] && !clr_mask[j]) |=> flags[j]);
  end
endmodule

bind capture_match_timer cmt_checker #(
  .CNT_W  (CNT_W),
  .N_MATCH(N_MATCH),
  .N_FLAG (N_MATCH + N_CAP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .srst     (srst_q),
  .tick     (tick),
  .wrap_req (rst_req_any),
  .counting (run_q),
  .count    (count_q),
  .match_evt(match_evt),
  .stop_vec (stop_vec),
  .flip_vec (flip_vec),
  .pins     (match_pin_o),
  .flags    (flag_q),
  .clr_mask (clr_mask)
);

// File: tb/tb_capture_match_timer.sv
`timescale 1ns/1ps
module tb_capture_match_timer;
  localparam int W = 32;
  localparam int NM = 4;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [NC-1:0] cap_in = '0;
  logic [W-1:0]  count_o;
  logic          counting_o;
  logic [NC*W-1:0] cap_val_o;
  logic [NM-1:0] match_pin_o;
  logic [NM+NC-1:0] irq_flag_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  capture_match_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_in(cap_in), .count_o(count_o), .counting_o(counting_o), .cap_val_o(cap_val_o),
    .match_pin_o(match_pin_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o)
  );

  // {prescale, wrap compare, cycles after start, expected count}
  localparam int VEC [0:5][0:3] = '{
    '{0, 1000,  7, 7},
    '{2, 1000, 10, 3},
    '{0,    4, 12, 2},
    '{1,    3, 17, 0},
    '{3,    2, 30, 1},
    '{0,    0,  5, 0}
  };

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(int addr, logic [W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] cap(int c);
    return cap_val_o[c*W +: W];
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 counting", 32'(counting_o), 0);
    check("R1 pins", 32'(match_pin_o), 0);
    check("R1 flags", 32'(irq_flag_o), 0);
    check("R1 irq", 32'(irq_o), 0);
    for (int c = 0; c < NC; c++) check("R1 capture", cap(c), 0);

    // R2 / R5 vector table
    for (int v = 0; v < 6; v++) begin
      wr(1, W'(VEC[v][0]));
      wr(8, W'(VEC[v][1]));
      wr(2, 32'h2);           // match0 wrap only
      wr(0, 32'h2);           // soft clear
      wr(0, 32'h1);           // run
      wait_cyc(VEC[v][2]);
      check((VEC[v][1] >= 1000) ? "R2 prescaled count" : "R5 wrap count",
            count_o, W'(VEC[v][3]));
    end

    // R3 soft clear overrides run
    wr(0, 32'h3);
    wait_cyc(6);
    check("R3 held count", count_o, 0);

    // R4 R6 R7 matches
    wr(1, 0);
    wr(8, 5); wr(9, 3); wr(10, 2); wr(11, 4);
    wr(2, (32'd21) | (32'd25 << 5) | (32'd16 << 15));
    wr(0, 32'h2); wr(0, 32'h1);
    wait_cyc(10);
    check("R6 halted count", count_o, 5);
    check("R6 counting low", 32'(counting_o), 0);
    check("R4 flags", 32'(irq_flag_o), 32'h03);
    check("R4 irq", 32'(irq_o), 1);
    check("R7 pins high/toggle/none", 32'(match_pin_o), 32'b1011);
    wr(4, 32'h1);
    check("R10 partial clear", 32'(irq_flag_o), 32'h02);
    check("R10 irq still set", 32'(irq_o), 1);
    wr(4, 32'h2);
    check("R10 irq after clear", 32'(irq_o), 0);

    wr(2, (32'd5) | (32'd25 << 5) | (32'd8 << 15));
    wr(0, 32'h2); wr(0, 32'h1);
    wait_cyc(10);
    check("R7 pins keep/toggle/low", 32'(match_pin_o), 32'b0001);
    check("R6 halted again", count_o, 5);
    wr(4, 32'hFF);

    // R8 R9 captures at count 5
    wr(3, (32'd5) | (32'd2 << 3) | (32'd7 << 6));
    @(negedge clk); cap_in[2:0] = 3'b111;
    wait_cyc(5);
    check("R8 rise capture", cap(0), 5);
    check("R8 fall-only ignores rise", cap(1), 0);
    check("R8 both-edge capture", cap(2), 5);
    check("R9 capture flags", 32'(irq_flag_o), 32'h50);

    wr(8, 9);
    wr(0, 32'h2); wr(0, 32'h1);
    wait_cyc(14);
    check("R6 halted at 9", count_o, 9);
    @(negedge clk); cap_in[2:1] = 2'b00;
    wait_cyc(5);
    check("R8 rise-only ignores fall", cap(0), 5);
    check("R8 fall capture", cap(1), 9);
    check("R8 both-edge fall", cap(2), 9);
    wr(4, 32'h40);
    check("R10 capture flag clear", 32'(irq_flag_o), 32'h13);
    wr(4, 32'hFF);

    // R11 external count on channel 3
    wr(2, 0);
    wr(0, 32'h2);
    @(negedge clk); cap_in[0] = 1'b0;
    wait_cyc(4);
    wr(0, 32'h1 | 32'h4 | (32'd3 << 3));
    wait_cyc(10);
    check("R11 no edges no count", count_o, 0);
    for (int p = 0; p < 3; p++) begin
      cap_in[3] = 1'b1; wait_cyc(3);
      cap_in[3] = 1'b0; wait_cyc(3);
    end
    wait_cyc(5);
    check("R11 edge count", count_o, 3);
    cap_in[0] = 1'b1;
    wait_cyc(5);
    check("R11 other channel captures", cap(0), 3);
    check("R11 count steady", count_o, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule